// File: doc/BRIEF.md
# Floating-Point NaN Result Selector

This block sits at the output of a two-operand single-precision floating-point unit. It decides what the unit returns when NaNs are involved. It receives both operands, the datapath's ordinary result, and a flag saying that the operation itself produced an invalid result with no NaN input. Alongside that flag comes a 3-bit cause code. A mode input picks one of several policies for the case where two NaNs meet. The block returns one registered 32-bit result, a flag saying the result is a NaN, and an invalid-operation flag.

Any signalling NaN that reaches the output is quieted first, and its other payload bits are kept. A NaN that the operation creates carries its cause code in the lowest payload bits. The canonical policy is the exception: it replaces every NaN result with one fixed pattern. Data moves on a valid/ready handshake, so a stalled consumer holds the result in place.

The handshake follows these rules. An item is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty, or when the consumer is taking its contents in that same cycle. While `out_valid` is high and `out_ready` is low, the result and both flags stay frozen. In that state no new item is taken.

Top module: `nanp_top`

## Requirements
- R1: While `rst_n` is low at a rising edge (synchronous, active low), the edge clears `out_valid`, `res`, `res_nan` and `res_invalid` to zero.
- R2: An item accepted on an edge appears on `res`, `res_nan` and `res_invalid`, with `out_valid` high, after that same edge. The outputs keep their values on any edge that accepts nothing. `in_ready` is low exactly when `out_valid` is high and `out_ready` is low.
- R3: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are nonzero. A NaN is signalling when bit 22 is 0. A NaN result taken from an operand has bit 22 forced to 1, and every other bit copied from that operand.
- R4: In modes 0 to 3, when exactly one operand is a NaN, the result is that operand (quieted).
- R5: In mode 0, when both operands are NaN, the result is operand A.
- R6: In mode 1, when both operands are NaN, the result is operand B.
- R7: In mode 2, when both operands are NaN, the result is operand A if B is signalling, and operand B otherwise.
- R8: In mode 3, when both operands are NaN, the result is operand B only if B is signalling and A is quiet; otherwise it is operand A.
- R9: In modes 4 to 7, every NaN result, whether taken from an operand or created, is exactly 0x7FC00000.
- R10: When `op_create` is 1 and neither operand is a NaN, modes 0 to 3 return 0x7FC00000 with `op_cause` placed in bits 2:0.
- R11: When neither operand is a NaN and `op_create` is 0, the result is `dp_result` unchanged.
- R12: `res_invalid` is 1 when either operand is a signalling NaN, or when a NaN is created (`op_create` with no NaN operand). Otherwise it is 0.
- R13: `res_nan` is 1 exactly when the registered result is a NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can take an item this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| dp_result | input | 32 | Datapath result used when no NaN is involved |
| op_create | input | 1 | The operation is invalid on non-NaN inputs |
| op_cause | input | 3 | Cause code for a created NaN |
| mode | input | 3 | Propagation policy, 0 to 7 |
| out_valid | output | 1 | Result register holds an item |
| out_ready | input | 1 | Consumer takes the item this cycle |
| res | output | 32 | Selected result |
| res_nan | output | 1 | Result is a NaN |
| res_invalid | output | 1 | Invalid-operation flag |

## Verification
The bound checker watches several behaviours on every cycle. It checks that reset clears the outputs. It checks that the result stays frozen under back-pressure or when no item is accepted. It checks that any result drawn from a NaN operand comes out quiet. It also checks the canonical pattern in modes 4 to 7 and the invalid flag for signalling inputs. Which operand wins in each two-NaN policy, the exact payload bits kept, the cause-code placement and the pass-through of the datapath result depend on operand values. Only the bench's reference model shows those, over directed corners and random mixes of quiet NaNs, signalling NaNs, infinities and ordinary numbers.

// File: rtl/nanp_pkg.sv
package nanp_pkg;

  typedef enum logic [2:0] {
    POL_FIRST  = 3'd0,
    POL_SECOND = 3'd1,
    POL_LEGACY = 3'd2,
    POL_SIGPRI = 3'd3,
    POL_CANON  = 3'd4
  } pol_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } fp_class_t;

endpackage

// File: rtl/nanp_classify.sv
module nanp_classify
  import nanp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op,
  output fp_class_t    cls,
  output logic [W-1:0] quieted
);

  logic exp_ones;
  logic frac_nz;

  assign exp_ones    = &op[W-2 -: EXP_W];
  assign frac_nz     = |op[FRAC_W-1:0];
  assign cls.is_nan  = exp_ones & frac_nz;
  assign cls.is_snan = exp_ones & frac_nz & ~op[FRAC_W-1];

  // Quiet bit is the fraction MSB; everything else is kept.
  always_comb begin
    quieted             = op;
    quieted[FRAC_W-1]   = 1'b1;
  end

endmodule

// File: rtl/nanp_policy.sv
module nanp_policy
  import nanp_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int CAUSE_W = 3,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input  fp_class_t          cls_a,
  input  fp_class_t          cls_b,
  input  logic [W-1:0]       qa,
  input  logic [W-1:0]       qb,
  input  logic [W-1:0]       dp,
  input  logic               create,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [2:0]         mode,
  output logic [W-1:0]       result,
  output logic               result_nan,
  output logic               invalid
);

  localparam logic [W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic any_nan;
  logic both_nan;
  logic canon;
  logic pick_b;
  logic dp_nan;
  logic made_nan;
  pol_e pol;

  assign pol      = pol_e'(mode);
  assign any_nan  = cls_a.is_nan | cls_b.is_nan;
  assign both_nan = cls_a.is_nan & cls_b.is_nan;
  assign canon    = mode[2];
  assign made_nan = create & ~any_nan;
  assign dp_nan   = (&dp[W-2 -: EXP_W]) & (|dp[FRAC_W-1:0]);

  // Which operand wins; only meaningful while any_nan is set.
  always_comb begin
    unique case (pol)
      POL_FIRST:  pick_b = ~cls_a.is_nan;
      POL_SECOND: pick_b = cls_b.is_nan;
      POL_LEGACY: pick_b = both_nan ? ~cls_b.is_snan : cls_b.is_nan;
      POL_SIGPRI: pick_b = both_nan ? (cls_b.is_snan & ~cls_a.is_snan)
                                    : cls_b.is_nan;
      default:    pick_b = 1'b0;
    endcase
  end

  always_comb begin
    if (any_nan) begin
      result = canon ? CANON_NAN : (pick_b ? qb : qa);
    end else if (made_nan) begin
      result = CANON_NAN;
      if (!canon) result[CAUSE_W-1:0] = cause;
    end else begin
      result = dp;
    end
  end

  assign result_nan = any_nan | made_nan | dp_nan;
  assign invalid    = cls_a.is_snan | cls_b.is_snan | made_nan;

endmodule

// File: rtl/nanp_stage.sv
module nanp_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d_res,
  input  logic         d_nan,
  input  logic         d_inv,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q_res,
  output logic         q_nan,
  output logic         q_inv
);

  logic accept;

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_res     <= '0;
      q_nan     <= 1'b0;
      q_inv     <= 1'b0;
    end else begin
      out_valid <= accept | (out_valid & ~out_ready);
      if (accept) begin
        q_res <= d_res;
        q_nan <= d_nan;
        q_inv <= d_inv;
      end
    end
  end

endmodule

// File: rtl/nanp_top.sv
module nanp_top
  import nanp_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int CAUSE_W = 3,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [W-1:0]       op_a,
  input  logic [W-1:0]       op_b,
  input  logic [W-1:0]       dp_result,
  input  logic               op_create,
  input  logic [CAUSE_W-1:0] op_cause,
  input  logic [2:0]         mode,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [W-1:0]       res,
  output logic               res_nan,
  output logic               res_invalid
);

  localparam int NOPS = 2;

  logic [W-1:0] ops  [NOPS];
  logic [W-1:0] qops [NOPS];
  fp_class_t    cls  [NOPS];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    nanp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op      (ops[i]),
      .cls     (cls[i]),
      .quieted (qops[i])
    );
  end

  logic [W-1:0] sel_res;
  logic         sel_nan;
  logic         sel_inv;

  nanp_policy #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .CAUSE_W(CAUSE_W)) u_pol (
    .cls_a      (cls[0]),
    .cls_b      (cls[1]),
    .qa         (qops[0]),
    .qb         (qops[1]),
    .dp         (dp_result),
    .create     (op_create),
    .cause      (op_cause),
    .mode       (mode),
    .result     (sel_res),
    .result_nan (sel_nan),
    .invalid    (sel_inv)
  );

  nanp_stage #(.W(W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_res     (sel_res),
    .d_nan     (sel_nan),
    .d_inv     (sel_inv),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_res     (res),
    .q_nan     (res_nan),
    .q_inv     (res_invalid)
  );

endmodule

// File: rtl/nanp_checker.sv
module nanp_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         op_create,
  input logic [2:0]   mode,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] res,
  input logic         res_nan,
  input logic         res_invalid
);

  localparam logic [W-1:0] CANON_PAT =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic take, a_nan, b_nan, a_sig, b_sig;
  assign take  = in_valid & in_ready;
  assign a_nan = (&op_a[W-2 -: EXP_W]) & (|op_a[FRAC_W-1:0]);
  assign b_nan = (&op_b[W-2 -: EXP_W]) & (|op_b[FRAC_W-1:0]);
  assign a_sig = a_nan & ~op_a[FRAC_W-1];
  assign b_sig = b_nan & ~op_b[FRAC_W-1];

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && res == '0 && !res_nan && !res_invalid));

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res) && $stable(res_nan)
                                   && $stable(res_invalid)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(res));

  assert_accept_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_quiet_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (a_nan || b_nan)) |=> (res[FRAC_W-1] && res_nan));

  assert_canon_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode[2] && (a_nan || b_nan || op_create)) |=> (res == CANON_PAT));

  assert_sig_invalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (a_sig || b_sig)) |=> res_invalid);

endmodule

bind nanp_top nanp_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .op_a        (op_a),
  .op_b        (op_b),
  .op_create   (op_create),
  .mode        (mode),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .res         (res),
  .res_nan     (res_nan),
  .res_invalid (res_invalid)
);

// File: tb/nanp_top_test.sv
module nanp_top_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CANON = 32'h7FC00000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0, op_b = '0, dp_result = '0;
  logic        op_create = 1'b0;
  logic [2:0]  op_cause = '0;
  logic [2:0]  mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] res;
  logic        res_nan, res_invalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nanp_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .dp_result(dp_result), .op_create(op_create),
    .op_cause(op_cause), .mode(mode), .out_valid(out_valid),
    .out_ready(out_ready), .res(res), .res_nan(res_nan),
    .res_invalid(res_invalid)
  );

  function automatic bit isnan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
  endfunction

  function automatic bit issig(input logic [31:0] v);
    return isnan(v) && !v[22];
  endfunction

  // Reference model from the requirements: {nan, invalid, result}
  function automatic logic [33:0] model(input logic [31:0] a, b, dp,
                                        input logic cr, input logic [2:0] cs,
                                        input logic [2:0] md);
    logic [31:0] r;
    logic n, iv;
    if (isnan(a) || isnan(b)) begin
      n = 1; iv = issig(a) || issig(b);
      if (md >= 3'd4) r = CANON;
      else begin
        if (!isnan(b)) r = a;
        else if (!isnan(a)) r = b;
        else if (md == 3'd0) r = a;
        else if (md == 3'd1) r = b;
        else if (md == 3'd2) r = issig(b) ? a : b;
        else r = (issig(b) && !issig(a)) ? b : a;
        r[22] = 1'b1;
      end
    end else if (cr) begin
      n = 1; iv = 1;
      r = (md >= 3'd4) ? CANON : (CANON | {29'd0, cs});
    end else begin
      r = dp; n = isnan(dp); iv = 0;
    end
    return {n, iv, r};
  endfunction

  function automatic string tag_of(input logic [31:0] a, b,
                                   input logic cr, input logic [2:0] md);
    if (isnan(a) || isnan(b)) begin
      if (md >= 3'd4) return "R9";
      if (!(isnan(a) && isnan(b))) return "R4/R3";
      case (md)
        3'd0: return "R5";
        3'd1: return "R6";
        3'd2: return "R7";
        default: return "R8";
      endcase
    end
    if (cr) return (md >= 3'd4) ? "R9" : "R10";
    return "R11";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, b, dp, input logic cr,
                      input logic [2:0] cs, md);
    logic [33:0] e;
    @(negedge clk);
    op_a = a; op_b = b; dp_result = dp; op_create = cr; op_cause = cs;
    mode = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = model(a, b, dp, cr, cs, md);
    check(tag_of(a, b, cr, md), res, e[31:0]);
    check("R13 res_nan", {31'd0, res_nan}, {31'd0, e[33]});
    check("R12 res_invalid", {31'd0, res_invalid}, {31'd0, e[32]});
    check("R2 out_valid", {31'd0, out_valid}, 32'd1);
  endtask

  function automatic logic [31:0] rand_op(input int kind);
    logic [31:0] v;
    v = $urandom;
    case (kind)
      0: begin v[30:23] = 8'hFF; v[22] = 1'b1; end
      1: begin v[30:23] = 8'hFF; v[22] = 1'b0;
               if (v[21:0] == 22'd0) v[0] = 1'b1; end
      2: begin v[30:23] = 8'hFF; v[22:0] = '0; end
      default: if (v[30:23] == 8'hFF) v[30] = 1'b0;
    endcase
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 res", res, 32'd0);
    check("R1 flags", {29'd0, out_valid, res_nan, res_invalid}, 32'd0);
    rst_n = 1'b1;

    // R5..R8: two NaNs, A quiet payload 0x11, B signalling payload 0x22
    for (int m = 0; m < 4; m++)
      send(32'h7FC00011, 32'h7F800022, 32'h3F800000, 1'b0, 3'd0, 3'(m));
    // both quiet
    for (int m = 0; m < 4; m++)
      send(32'hFFC00033, 32'h7FC00044, 32'h0, 1'b0, 3'd0, 3'(m));
    // A signalling, B quiet
    for (int m = 0; m < 4; m++)
      send(32'h7F800055, 32'hFFC00066, 32'h0, 1'b0, 3'd0, 3'(m));
    // R4/R3: single sNaN quieted
    send(32'h3F800000, 32'hFF812345, 32'h0, 1'b0, 3'd0, 3'd0);
    send(32'h7F8ABCDE, 32'h40000000, 32'h0, 1'b0, 3'd0, 3'd1);
    // R9: canonical, including created
    send(32'h7F800001, 32'h7FC00002, 32'h0, 1'b0, 3'd0, 3'd4);
    send(32'h1, 32'h2, 32'h0, 1'b1, 3'd5, 3'd7);
    // R10: created NaN with cause
    send(32'h7F800000, 32'h0, 32'h0, 1'b1, 3'd6, 3'd2);
    // R11: pass-through of datapath, including infinity operands
    send(32'h7F800000, 32'hFF800000, 32'h12345678, 1'b0, 3'd3, 3'd0);

    // R2: hold without an accepted item
    held = res;
    repeat (3) @(negedge clk);
    check("R2 idle hold", res, held);

    // R2: back-pressure
    out_ready = 1'b0;
    send(32'h7FC000AA, 32'h0, 32'h0, 1'b0, 3'd0, 3'd0);
    held = res;
    op_a = 32'h7FC000BB; in_valid = 1'b1;
    #1 check("R2 in_ready low", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    check("R2 stall hold", res, held);
    out_ready = 1'b1;
    #1 check("R2 in_ready high", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 after stall", res, 32'h7FC000BB);

    // random mix
    for (int i = 0; i < 400; i++)
      send(rand_op($urandom_range(0, 4)), rand_op($urandom_range(0, 4)),
           rand_op($urandom_range(0, 4)), 1'($urandom), 3'($urandom),
           3'($urandom));

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", {res[31:3], res[2:0] | {out_valid, res_nan, res_invalid}}, 32'd0);
    rst_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule